// File: doc/BRIEF.md
# Smart Card Session Fault Controller

This block is the digital control core of a single-slot smart card interface. The host requests a card session through an active-low activate command. The block checks that a card is present, then switches on the card supply, the I/O line, the card clock and finally the reset pass-through. It switches them on one step at a time, at a rate set by a step counter. When the session ends, the enables are removed in the reverse order. The session ends when the host releases the command, or at once when a fault or a card removal is seen.

A single active-low interrupt line serves two purposes. Outside a session it shows whether a card is inserted. Inside a session it drops, and stays low, once a fault has forced a deactivation. It remains low until the host withdraws the activate command. Before the block acts on the card-detect inputs or the four fault flags (supply undervoltage, card supply failure, over-current, over-temperature), each of them passes through a two-stage synchroniser and a debounce filter.

Top module: `sc_session_ctrl`

## Requirements
- R1: After reset, all card enables and `rst_out` are 0, `pd_mode` is 0, `volt_5v` is 1 (the 5 V default), and `irq_n` is 0 because no card is seen.
- R2: A card counts as present when `det_hi` is 1 or `det_lo_n` is 0. Outside a session, `irq_n` is 1 while a card is present and 0 while none is present.
- R3: Driving `act_req_n` low with no card present does not start a session, so `sup_en` stays 0.
- R4: With a card present and `act_req_n` low, the enables rise in the order `sup_en`, `io_en`, `clk_en`, then the reset pass-through. Each rise falls on a later cycle than the one before it.
- R5: `rst_out` is 0 until the reset pass-through stage is reached. From that stage on, `rst_out` equals `host_rst`.
- R6: A debounced fault flag, or loss of card presence during a session, starts a deactivation without host action. The enables then fall in the order `clk_en`, `io_en`, `sup_en`, and `irq_n` goes low.
- R7: After a fault deactivation, `irq_n` stays low even once the fault clears, for as long as `act_req_n` stays low. When `act_req_n` returns high, the block goes idle and `irq_n` shows card presence again.
- R8: When the host raises `act_req_n` during a session with no fault, all enables fall and `irq_n` stays high throughout.
- R9: `pwrdn_req` sets `pd_mode` only when the block is idle and `act_req_n` is high. During a session, or while `act_req_n` is low, it has no effect.
- R10: `volt_5v` takes the value of `volt_sel` (1 = 5 V, 0 = 3 V) when a session starts, and holds that value for the whole session.
- R11: A presence or fault input change lasting fewer than `DEB_CYCLES` cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_req_n | input | 1 | Host activate command, active low |
| host_rst | input | 1 | Host reset level for the card |
| volt_sel | input | 1 | Card voltage select, 1 = 5 V, 0 = 3 V |
| pwrdn_req | input | 1 | Host power-down request |
| det_hi | input | 1 | Card detect, high when a card is inserted |
| det_lo_n | input | 1 | Card detect, low when a card is inserted |
| flt_uv | input | 1 | Supply undervoltage flag |
| flt_vcc | input | 1 | Card supply failure flag |
| flt_oc | input | 1 | Card over-current flag |
| flt_temp | input | 1 | Over-temperature flag |
| irq_n | output | 1 | Interrupt, active low (open-drain pull-down request) |
| sup_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O enable |
| clk_en | output | 1 | Card clock enable |
| rst_out | output | 1 | Card reset contact level |
| volt_5v | output | 1 | Selected card voltage, 1 = 5 V |
| pd_mode | output | 1 | Power-down mode active |

## Verification
Card presence is driven through each detect input in turn. This confirms that either polarity alone makes the interrupt line read as present. An activate request is made both without and with a card, which separates a refused start from a real one. A session is ended in three ways: by an over-temperature fault, by card removal, and by the host releasing the command. These show whether the interrupt line latches on faults only. A fault pulse shorter than the debounce window, and power-down requests made inside and outside a session, check that those inputs are ignored exactly when they should be.

// File: rtl/sc_session_ctrl.sv
module sc_session_ctrl #(
  parameter int DEB_CYCLES  = 8,
  parameter int STEP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_req_n,
  input  logic host_rst,
  input  logic volt_sel,
  input  logic pwrdn_req,
  input  logic det_hi,
  input  logic det_lo_n,
  input  logic flt_uv,
  input  logic flt_vcc,
  input  logic flt_oc,
  input  logic flt_temp,
  output logic irq_n,
  output logic sup_en,
  output logic io_en,
  output logic clk_en,
  output logic rst_out,
  output logic volt_5v,
  output logic pd_mode
);
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam int TW = $clog2(STEP_CYCLES + 1);
  localparam int NIN = 6;
  localparam logic [NIN-1:0] RSTV = 6'b000010;

  typedef enum logic [2:0] {IDLE, POWERDOWN, ACTIVATING, ACTIVE, DEACTIVATING, FAULT_WAIT} state_t;

  logic [NIN-1:0] raw, s1, s2, db;
  assign raw = {flt_temp, flt_oc, flt_vcc, flt_uv, det_lo_n, det_hi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= RSTV;
      s2 <= RSTV;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar g = 0; g < NIN; g++) begin : g_deb
    logic [DW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt   <= '0;
        db[g] <= RSTV[g];
      end else if (s2[g] == db[g]) begin
        cnt <= '0;
      end else if (cnt == DW'(DEB_CYCLES - 1)) begin
        cnt   <= '0;
        db[g] <= s2[g];
      end else begin
        cnt <= cnt + 1'b1;
      end
  end

  logic present, fault;
  assign present = db[0] | ~db[1];
  assign fault   = |db[5:2];

  state_t state;
  logic [2:0] stage;
  logic [TW-1:0] tcnt;
  logic flt_lat, in_seq, tick, session;

  assign in_seq = (state == ACTIVATING) || (state == DEACTIVATING);
  assign tick   = in_seq && (tcnt == TW'(STEP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           tcnt <= '0;
    else if (!in_seq || tick) tcnt <= '0;
    else                  tcnt <= tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= IDLE;
      stage   <= '0;
      flt_lat <= 1'b0;
      volt_5v <= 1'b1;
    end else begin
      case (state)
        IDLE: begin
          flt_lat <= 1'b0;
          if (!act_req_n && present) begin
            state   <= ACTIVATING;
            volt_5v <= volt_sel;
          end else if (act_req_n && pwrdn_req) begin
            state <= POWERDOWN;
          end
        end
        POWERDOWN:
          if (!pwrdn_req || !act_req_n) state <= IDLE;
        ACTIVATING:
          if (fault || !present) begin
            flt_lat <= 1'b1;
            state   <= DEACTIVATING;
          end else if (act_req_n) begin
            state <= DEACTIVATING;
          end else if (tick) begin
            stage <= stage + 3'd1;
            if (stage == 3'd3) state <= ACTIVE;
          end
        ACTIVE:
          if (fault || !present) begin
            flt_lat <= 1'b1;
            state   <= DEACTIVATING;
          end else if (act_req_n) begin
            state <= DEACTIVATING;
          end
        DEACTIVATING:
          if (tick) begin
            if (stage == 3'd0) state <= flt_lat ? FAULT_WAIT : IDLE;
            else               stage <= stage - 3'd1;
          end
        FAULT_WAIT:
          if (act_req_n) begin
            state   <= IDLE;
            flt_lat <= 1'b0;
          end
        default: state <= IDLE;
      endcase
    end

  assign session = (state != IDLE) && (state != POWERDOWN);
  assign sup_en  = stage >= 3'd1;
  assign io_en   = stage >= 3'd2;
  assign clk_en  = stage >= 3'd3;
  assign rst_out = (stage == 3'd4) && host_rst;
  assign pd_mode = state == POWERDOWN;
  assign irq_n   = session ? ~flt_lat : present;

  a_r3_no_card_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && !present) |=> state != ACTIVATING);
  a_r5_rst_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !rst_out);
  a_r6_fault_deact: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ACTIVE && fault) |=> (state == DEACTIVATING && !irq_n));
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FAULT_WAIT && !act_req_n) |=> !irq_n);
  a_r9_no_pd_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    pd_mode |-> !sup_en);
  a_r10_volt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en && $past(sup_en)) |-> $stable(volt_5v));
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sup_en, io_en, clk_en} ^ $past({sup_en, io_en, clk_en})) <= 1);
endmodule

// File: tb/sc_session_ctrl_tb.sv
`timescale 1ns/1ps
module sc_session_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic act_req_n = 1, host_rst = 0, volt_sel = 1, pwrdn_req = 0;
  logic det_hi = 0, det_lo_n = 1, flt_uv = 0, flt_vcc = 0, flt_oc = 0, flt_temp = 0;
  logic irq_n, sup_en, io_en, clk_en, rst_out, volt_5v, pd_mode;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sc_session_ctrl u_dut (.clk, .rst_n, .act_req_n, .host_rst, .volt_sel, .pwrdn_req,
    .det_hi, .det_lo_n, .flt_uv, .flt_vcc, .flt_oc, .flt_temp,
    .irq_n, .sup_en, .io_en, .clk_en, .rst_out, .volt_5v, .pd_mode);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(sup_en == 0 && io_en == 0 && clk_en == 0 && rst_out == 0, "R1 enables", {sup_en, io_en, clk_en, rst_out}, 0);
    chk(pd_mode == 0, "R1 pd_mode", pd_mode, 0);
    chk(volt_5v == 1, "R1 volt default", volt_5v, 1);
    chk(irq_n == 0, "R1 irq no card", irq_n, 0);
  endtask

  task automatic t_presence;
    det_hi = 1; wait_cyc(30);
    chk(irq_n == 1, "R2 det_hi present", irq_n, 1);
    det_hi = 0; det_lo_n = 0; wait_cyc(30);
    chk(irq_n == 1, "R2 det_lo_n present", irq_n, 1);
    det_lo_n = 1; wait_cyc(30);
    chk(irq_n == 0, "R2 absent", irq_n, 0);
  endtask

  task automatic t_no_card;
    act_req_n = 0; wait_cyc(40);
    chk(sup_en == 0, "R3 no card no start", sup_en, 0);
    act_req_n = 1; wait_cyc(5);
  endtask

  task automatic t_pwrdn_idle;
    act_req_n = 0; pwrdn_req = 1; wait_cyc(10);
    chk(pd_mode == 0, "R9 pd ignored with act low", pd_mode, 0);
    act_req_n = 1; wait_cyc(5);
    chk(pd_mode == 1, "R9 pd honoured idle", pd_mode, 1);
    pwrdn_req = 0; wait_cyc(5);
    chk(pd_mode == 0, "R9 pd released", pd_mode, 0);
  endtask

  task automatic t_activate;
    int r_sup = -1, r_io = -1, r_clk = -1, r_rst = -1;
    bit early_rst = 0;
    det_lo_n = 0; volt_sel = 0; host_rst = 1; wait_cyc(30);
    act_req_n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sup_en && r_sup < 0) r_sup = i;
      if (io_en && r_io < 0) r_io = i;
      if (clk_en && r_clk < 0) r_clk = i;
      if (rst_out && r_rst < 0) r_rst = i;
      if (rst_out && !clk_en) early_rst = 1;
    end
    chk(r_sup >= 0 && r_sup < r_io && r_io < r_clk, "R4 order sup/io/clk", r_io, r_sup + 1);
    chk(r_rst > r_clk, "R5 reset after clock", r_rst, r_clk + 1);
    chk(!early_rst, "R5 no early reset", early_rst, 0);
    chk(volt_5v == 0, "R10 3V sampled", volt_5v, 0);
    chk(irq_n == 1, "R8 irq high in clean session", irq_n, 1);
    volt_sel = 1; host_rst = 0; wait_cyc(5);
    chk(volt_5v == 0, "R10 volt held", volt_5v, 0);
    chk(rst_out == 0, "R5 rst follows host low", rst_out, 0);
    host_rst = 1; wait_cyc(2);
    chk(rst_out == 1, "R5 rst follows host high", rst_out, 1);
  endtask

  task automatic t_pd_in_session;
    pwrdn_req = 1; wait_cyc(20);
    chk(pd_mode == 0 && sup_en == 1, "R9 pd ignored in session", pd_mode, 0);
    pwrdn_req = 0; wait_cyc(2);
  endtask

  task automatic t_glitch;
    flt_oc = 1; wait_cyc(3); flt_oc = 0; wait_cyc(30);
    chk(irq_n == 1 && sup_en == 1, "R11 glitch ignored", irq_n, 1);
  endtask

  task automatic t_fault;
    int f_sup = -1, f_io = -1, f_clk = -1;
    flt_temp = 1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (i == 20) flt_temp = 0;
      if (!sup_en && f_sup < 0) f_sup = i;
      if (!io_en && f_io < 0) f_io = i;
      if (!clk_en && f_clk < 0) f_clk = i;
    end
    chk(f_clk >= 0 && f_clk < f_io && f_io < f_sup, "R6 reverse order", f_io, f_clk + 1);
    chk(irq_n == 0, "R6 irq low on fault", irq_n, 0);
    wait_cyc(30);
    chk(irq_n == 0 && sup_en == 0, "R7 irq latched", irq_n, 0);
    act_req_n = 1; wait_cyc(5);
    chk(irq_n == 1, "R7 back to presence", irq_n, 1);
  endtask

  task automatic t_host_deact;
    bit saw_low = 0;
    act_req_n = 0; wait_cyc(40);
    chk(clk_en == 1, "R4 reactivated", clk_en, 1);
    act_req_n = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!irq_n) saw_low = 1;
    end
    chk(sup_en == 0, "R8 deactivated", sup_en, 0);
    chk(!saw_low, "R8 irq stayed high", saw_low, 0);
  endtask

  task automatic t_removal;
    act_req_n = 0; wait_cyc(40);
    det_lo_n = 1; wait_cyc(60);
    chk(sup_en == 0 && irq_n == 0, "R6 removal deactivates", {sup_en, irq_n}, 0);
    act_req_n = 1; wait_cyc(5);
    chk(irq_n == 0, "R7 idle shows no card", irq_n, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    t_reset;
    t_presence;
    t_no_card;
    t_pwrdn_idle;
    t_activate;
    t_pd_in_session;
    t_glitch;
    t_fault;
    t_host_deact;
    t_removal;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule